// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block takes one 64-bit instruction word and issues its contents to the execution units. Two format bits in the word pick one of four issue modes. In the first mode the whole word is issued as a single wide operation. In the second and third modes the two 32-bit halves are issued one after the other, in either direction. In the fourth mode the halves are issued concurrently on two lanes. The block decides which unit gets each half, when the register write-commit step fires, whether the second half may run at all, and which next-PC value the instruction produces.

Lane 0 carries the wide operation and every sequential issue, and it tags each one with a unit code. Lane 1 is used only for the integer half of a concurrent pair. Each lane uses a request/done handshake. On done, the unit reports a jump flag with a target and a kill-next flag, and lane 0 also reports a system-move flag. The sequencer pulses `commit_o` at each write-commit point. It ends the instruction with a one-cycle `done_o`, which carries the merged next PC.

Top module: `issue_seq`

## Requirements
- R1: The mode is the 2-bit value {word_i[63], word_i[31]}: 3 is wide, 1 is left-half-first, 2 is right-half-first, 0 is concurrent. The left half is word_i[63:32] and the right half is word_i[31:0].
- R2: A wide word is issued once on lane 0 with unit code 3 and the full 64-bit word. It is followed by exactly one commit. Its next PC is its own jump target, or invalid if it did not jump.
- R3: In left-first mode the left half goes out first on lane 0 with unit code 0 (memory). In right-first mode the right half goes out first with unit code 1 (integer). A short half travels in lane0_word_o[31:0], with bits [63:32] zero.
- R4: In sequential modes a commit follows the first half. The other half is then issued on lane 0 with unit code 2 (any unit), and only if the first half neither jumped nor raised kill-next. A second commit follows it.
- R5: Sequential next PC: the first half's target if it jumped. Otherwise, the second half's result if that half was issued. Otherwise invalid. nia_o reads zero whenever nia_valid_o is low.
- R6: In concurrent mode the left half goes on lane 0 with unit code 0 and the right half on lane 1, both requested in the same cycle. A single commit follows once both lanes are done, in either order.
- R7: Concurrent merge: when exactly one lane jumps, its target is the next PC. When neither lane jumps, the next PC is invalid. When both lanes jump, nia_err_o is high with done_o and nia_valid_o is low.
- R8: The kill-next and system-move flags clear when an instruction starts and when it ends. commit_sysmv_o is high on a commit only if lane 0 reported system-move earlier in the same instruction. A kill from one instruction never suppresses the second half of the next one.
- R9: Each commit pulse comes exactly one cycle after the cycle in which the last awaited done is accepted. done_o comes exactly one cycle after the final commit. Both pulses last one cycle.
- R10: A lane request stays high, with stable word and unit code, until its done is accepted. It then drops in the next cycle.
- R11: start_i is taken only while idle_o is high. A start while busy changes neither the issues nor the result of the current instruction.
- R12: After reset the block is idle, with no request, commit or done asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction (taken when idle) |
| word_i | input | 64 | Instruction word sampled with start_i |
| idle_o | output | 1 | Ready for a new instruction |
| lane0_req_o | output | 1 | Lane 0 issue request |
| lane0_unit_o | output | 2 | Lane 0 unit code: 0 memory, 1 integer, 2 any, 3 wide |
| lane0_word_o | output | 64 | Lane 0 payload |
| lane0_done_i | input | 1 | Lane 0 execution finished |
| lane0_jump_i | input | 1 | Lane 0 produced a jump |
| lane0_target_i | input | 32 | Lane 0 jump target |
| lane0_kill_i | input | 1 | Lane 0 kill-next request |
| lane0_sysmv_i | input | 1 | Lane 0 executed a system-register move |
| lane1_req_o | output | 1 | Lane 1 (integer) issue request |
| lane1_word_o | output | 32 | Lane 1 payload (right half) |
| lane1_done_i | input | 1 | Lane 1 execution finished |
| lane1_jump_i | input | 1 | Lane 1 produced a jump |
| lane1_target_i | input | 32 | Lane 1 jump target |
| commit_o | output | 1 | Write-commit pulse |
| commit_sysmv_o | output | 1 | System-move seen, qualified by commit_o |
| done_o | output | 1 | Instruction complete pulse |
| nia_valid_o | output | 1 | Next PC is a jump target (with done_o) |
| nia_o | output | 32 | Merged next PC |
| nia_err_o | output | 1 | Both concurrent lanes jumped (with done_o) |

## Verification
A wrong state register shows up directly in the handshake. A missing or doubled request appears within one cycle of the commit that should precede it, and so does a wrong unit code on the second issue. A kill or system-move flag that lingers is caught only on a later instruction. The bench therefore places sequential words that neither kill nor move right after words that do. A wrong merge is seen on the single done cycle. The reference model therefore compares the whole next-PC triple there, and it times every commit and done against the cycle of the accepted done.

// File: rtl/issue_seq_pkg.sv
package issue_seq_pkg;

    typedef enum logic [1:0] {
        UNIT_MEM  = 2'd0,
        UNIT_INT  = 2'd1,
        UNIT_ANY  = 2'd2,
        UNIT_WIDE = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        FMT_PAR    = 2'd0,
        FMT_LFIRST = 2'd1,
        FMT_RFIRST = 2'd2,
        FMT_WIDE   = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SLOT1   = 3'd1,
        ST_COMMIT1 = 3'd2,
        ST_SLOT2   = 3'd3,
        ST_COMMIT2 = 3'd4,
        ST_DONE    = 3'd5
    } state_e;

endpackage

// File: rtl/issue_seq_decode.sv
module issue_seq_decode
    import issue_seq_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic [2*HALF_W-1:0] word_i,
    output fmt_e                fmt_o,
    output logic [2*HALF_W-1:0] first_word_o,
    output unit_e               first_unit_o,
    output logic [HALF_W-1:0]   second_half_o
);
    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] left_h;
    logic [HALF_W-1:0] right_h;

    assign left_h  = word_i[WORD_W-1:HALF_W];
    assign right_h = word_i[HALF_W-1:0];
    assign fmt_o   = fmt_e'({word_i[WORD_W-1], word_i[HALF_W-1]});

    always_comb begin
        first_word_o  = {{HALF_W{1'b0}}, left_h};
        first_unit_o  = UNIT_MEM;
        second_half_o = right_h;
        case (fmt_o)
            FMT_WIDE: begin
                first_word_o  = word_i;
                first_unit_o  = UNIT_WIDE;
                second_half_o = '0;
            end
            FMT_RFIRST: begin
                first_word_o  = {{HALF_W{1'b0}}, right_h};
                first_unit_o  = UNIT_INT;
                second_half_o = left_h;
            end
            default: begin
                first_word_o  = {{HALF_W{1'b0}}, left_h};
                first_unit_o  = UNIT_MEM;
                second_half_o = right_h;
            end
        endcase
    end

endmodule

// File: rtl/issue_seq_merge.sv
module issue_seq_merge #(
    parameter int HALF_W = 32
) (
    input  logic              a_jump_i,
    input  logic [HALF_W-1:0] a_tgt_i,
    input  logic              b_jump_i,
    input  logic [HALF_W-1:0] b_tgt_i,
    output logic              valid_o,
    output logic [HALF_W-1:0] tgt_o,
    output logic              err_o
);
    always_comb begin
        valid_o = 1'b0;
        tgt_o   = '0;
        err_o   = 1'b0;
        case ({a_jump_i, b_jump_i})
            2'b10: begin
                valid_o = 1'b1;
                tgt_o   = a_tgt_i;
            end
            2'b01: begin
                valid_o = 1'b1;
                tgt_o   = b_tgt_i;
            end
            2'b11: err_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/issue_seq.sv
module issue_seq
    import issue_seq_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*HALF_W-1:0] word_i,
    output logic                idle_o,
    output logic                lane0_req_o,
    output logic [1:0]          lane0_unit_o,
    output logic [2*HALF_W-1:0] lane0_word_o,
    input  logic                lane0_done_i,
    input  logic                lane0_jump_i,
    input  logic [HALF_W-1:0]   lane0_target_i,
    input  logic                lane0_kill_i,
    input  logic                lane0_sysmv_i,
    output logic                lane1_req_o,
    output logic [HALF_W-1:0]   lane1_word_o,
    input  logic                lane1_done_i,
    input  logic                lane1_jump_i,
    input  logic [HALF_W-1:0]   lane1_target_i,
    output logic                commit_o,
    output logic                commit_sysmv_o,
    output logic                done_o,
    output logic                nia_valid_o,
    output logic [HALF_W-1:0]   nia_o,
    output logic                nia_err_o
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        state_e            st;
        logic [WORD_W-1:0] word;
        logic              got0;
        logic              got1;
        logic              j0;
        logic [HALF_W-1:0] t0;
        logic              j1;
        logic [HALF_W-1:0] t1;
        logic              kill;
        logic              sysmv;
        logic              nia_v;
        logic [HALF_W-1:0] nia;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    fmt_e              fmt;
    logic [WORD_W-1:0] first_word;
    unit_e             first_unit;
    logic [HALF_W-1:0] second_half;
    logic              mrg_valid;
    logic [HALF_W-1:0] mrg_tgt;
    logic              mrg_err;
    logic              take0;
    logic              take1;

    issue_seq_decode #(.HALF_W(HALF_W)) dec_i (
        .word_i        (r_q.word),
        .fmt_o         (fmt),
        .first_word_o  (first_word),
        .first_unit_o  (first_unit),
        .second_half_o (second_half)
    );

    issue_seq_merge #(.HALF_W(HALF_W)) mrg_i (
        .a_jump_i (r_q.j0),
        .a_tgt_i  (r_q.t0),
        .b_jump_i (r_q.j1),
        .b_tgt_i  (r_q.t1),
        .valid_o  (mrg_valid),
        .tgt_o    (mrg_tgt),
        .err_o    (mrg_err)
    );

    // Outputs are decoded from registered state only.
    assign idle_o       = (r_q.st == ST_IDLE);
    assign lane0_req_o  = ((r_q.st == ST_SLOT1) || (r_q.st == ST_SLOT2)) && !r_q.got0;
    assign lane0_unit_o = (r_q.st == ST_SLOT2) ? UNIT_ANY : first_unit;
    assign lane0_word_o = (r_q.st == ST_SLOT2) ? {{HALF_W{1'b0}}, second_half} : first_word;
    assign lane1_req_o  = (r_q.st == ST_SLOT1) && (fmt == FMT_PAR) && !r_q.got1;
    assign lane1_word_o = second_half;
    assign commit_o       = (r_q.st == ST_COMMIT1) || (r_q.st == ST_COMMIT2);
    assign commit_sysmv_o = commit_o && r_q.sysmv;
    assign done_o         = (r_q.st == ST_DONE);
    assign nia_valid_o    = done_o && r_q.nia_v;
    assign nia_o          = nia_valid_o ? r_q.nia : '0;
    assign nia_err_o      = done_o && r_q.err;

    assign take0 = lane0_req_o && lane0_done_i;
    assign take1 = lane1_req_o && lane1_done_i;

    always_comb begin
        r_d = r_q;

        if (take0) begin
            r_d.got0 = 1'b1;
            r_d.j0   = lane0_jump_i;
            r_d.t0   = lane0_target_i;
            if (lane0_kill_i)  r_d.kill  = 1'b1;
            if (lane0_sysmv_i) r_d.sysmv = 1'b1;
        end
        if (take1) begin
            r_d.got1 = 1'b1;
            r_d.j1   = lane1_jump_i;
            r_d.t1   = lane1_target_i;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_SLOT1;
                    r_d.word  = word_i;
                    r_d.got0  = 1'b0;
                    r_d.got1  = 1'b0;
                    r_d.j0    = 1'b0;
                    r_d.j1    = 1'b0;
                    r_d.kill  = 1'b0;
                    r_d.sysmv = 1'b0;
                    r_d.nia_v = 1'b0;
                    r_d.nia   = '0;
                    r_d.err   = 1'b0;
                end
            end
            ST_SLOT1: begin
                if (r_d.got0 && (r_d.got1 || (fmt != FMT_PAR)))
                    r_d.st = ST_COMMIT1;
            end
            ST_COMMIT1: begin
                r_d.st = ST_DONE;
                if (fmt == FMT_PAR) begin
                    r_d.nia_v = mrg_valid;
                    r_d.nia   = mrg_tgt;
                    r_d.err   = mrg_err;
                end else if (fmt == FMT_WIDE || r_q.j0 || r_q.kill) begin
                    r_d.nia_v = r_q.j0;
                    r_d.nia   = r_q.t0;
                end else begin
                    r_d.st   = ST_SLOT2;
                    r_d.got0 = 1'b0;
                end
            end
            ST_SLOT2: begin
                if (r_d.got0)
                    r_d.st = ST_COMMIT2;
            end
            ST_COMMIT2: begin
                r_d.st    = ST_DONE;
                r_d.nia_v = r_q.j0;
                r_d.nia   = r_q.t0;
            end
            ST_DONE: begin
                r_d.st    = ST_IDLE;
                r_d.kill  = 1'b0;
                r_d.sysmv = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk #(
    parameter int HALF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                idle_o,
    input logic                lane0_req_o,
    input logic                lane0_done_i,
    input logic [1:0]          lane0_unit_o,
    input logic [2*HALF_W-1:0] lane0_word_o,
    input logic                lane1_req_o,
    input logic                commit_o,
    input logic                done_o,
    input logic                nia_valid_o,
    input logic                nia_err_o
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(commit_o));

    // R9
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_o, done_o, lane0_req_o, idle_o}));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane0_req_o && !lane0_done_i |=> lane0_req_o && $stable(lane0_word_o) && $stable(lane0_unit_o));

    // R7
    err_no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nia_err_o |-> done_o && !nia_valid_o);

    // R11
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o && start_i |=> !idle_o);

    // R6
    lane1_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane1_req_o |-> !idle_o && !commit_o && !done_o);

endmodule

bind issue_seq issue_seq_chk #(.HALF_W(HALF_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .idle_o       (idle_o),
    .lane0_req_o  (lane0_req_o),
    .lane0_done_i (lane0_done_i),
    .lane0_unit_o (lane0_unit_o),
    .lane0_word_o (lane0_word_o),
    .lane1_req_o  (lane1_req_o),
    .commit_o     (commit_o),
    .done_o       (done_o),
    .nia_valid_o  (nia_valid_o),
    .nia_err_o    (nia_err_o)
);

// File: tb/issue_seq_tb_top.sv
`timescale 1ns/1ps
module issue_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] word_i = '0;
    logic        idle_o;
    logic        lane0_req_o;
    logic [1:0]  lane0_unit_o;
    logic [63:0] lane0_word_o;
    logic        lane0_done_i = 1'b0;
    logic        lane0_jump_i = 1'b0;
    logic [31:0] lane0_target_i = '0;
    logic        lane0_kill_i = 1'b0;
    logic        lane0_sysmv_i = 1'b0;
    logic        lane1_req_o;
    logic [31:0] lane1_word_o;
    logic        lane1_done_i = 1'b0;
    logic        lane1_jump_i = 1'b0;
    logic [31:0] lane1_target_i = '0;
    logic        commit_o;
    logic        commit_sysmv_o;
    logic        done_o;
    logic        nia_valid_o;
    logic [31:0] nia_o;
    logic        nia_err_o;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    issue_seq #(.HALF_W(32)) dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [1:0] f, input logic [31:0] l, input logic [31:0] r);
        return {f[1], l[30:0], f[0], r[30:0]};
    endfunction

    // Reference model: one instruction, the bench acting as both execution units.
    task automatic run(input logic [63:0] w,
                       input bit aj, input logic [31:0] at, input bit ak, input bit as,
                       input bit bj, input logic [31:0] bt, input bit bs,
                       input int la, input int lb, input bit poke);
        logic [1:0]  f;
        logic [63:0] e_w0, e_w1;
        logic [1:0]  e_u0;
        bit          seq, second, e_v, e_err, got_done, pend0, pend1;
        logic [31:0] e_t;
        int          e_iss0, e_iss1, e_com, k0, k1, ncom, cnt0, cnt1, last_done, last_com;
        bit          sys_acc;
        f = {w[63], w[31]};
        seq = (f == 2'd1) || (f == 2'd2);
        second = seq && !aj && !ak;
        e_w1 = '0; e_err = 1'b0;
        case (f)
            2'd3: begin e_w0 = w; e_u0 = 2'd3; end
            2'd1: begin e_w0 = {32'h0, w[63:32]}; e_u0 = 2'd0; e_w1 = {32'h0, w[31:0]}; end
            2'd2: begin e_w0 = {32'h0, w[31:0]}; e_u0 = 2'd1; e_w1 = {32'h0, w[63:32]}; end
            default: begin e_w0 = {32'h0, w[63:32]}; e_u0 = 2'd0; end
        endcase
        e_iss0 = 1 + (second ? 1 : 0);
        e_iss1 = (f == 2'd0) ? 1 : 0;
        e_com  = 1 + (second ? 1 : 0);
        if (f == 2'd0) begin
            e_err = aj && bj;
            e_v   = aj ^ bj;
            e_t   = e_v ? (aj ? at : bt) : 32'h0;
        end else if (aj) begin
            e_v = 1'b1; e_t = at;
        end else if (second && bj) begin
            e_v = 1'b1; e_t = bt;
        end else begin
            e_v = 1'b0; e_t = 32'h0;
        end

        @(negedge clk);
        check(idle_o == 1'b1, "R11", "idle before start", {63'h0, idle_o}, 64'h1);
        start_i = 1'b1; word_i = w;
        k0 = 0; k1 = 0; ncom = 0; pend0 = 0; pend1 = 0; cnt0 = 0; cnt1 = 0;
        last_done = -10; last_com = -10; sys_acc = 1'b0; got_done = 1'b0;
        for (int cyc = 0; cyc < 60 && !got_done; cyc++) begin
            @(negedge clk);
            start_i = 1'b0; word_i = 64'h0123_4567_89ab_cdef;
            lane0_done_i = 1'b0; lane1_done_i = 1'b0;
            if (poke && cyc == 1) begin
                start_i = 1'b1; word_i = ~w;   // R11: must be ignored while busy
            end
            if (lane0_req_o && !pend0) begin
                k0++;
                check(lane0_word_o == (k0 == 1 ? e_w0 : e_w1), (k0 == 1) ? "R3" : "R4",
                      "lane0 word", lane0_word_o, (k0 == 1) ? e_w0 : e_w1);
                check(lane0_unit_o == (k0 == 1 ? e_u0 : 2'd2), (k0 == 1) ? "R1" : "R4",
                      "lane0 unit", {62'h0, lane0_unit_o}, {62'h0, (k0 == 1) ? e_u0 : 2'd2});
                if (f == 2'd0 && k0 == 1)
                    check(lane1_req_o == 1'b1, "R6", "lanes requested together",
                          {63'h0, lane1_req_o}, 64'h1);
                cnt0 = (k0 == 1) ? la : lb; pend0 = 1;
            end
            if (lane1_req_o && !pend1) begin
                k1++;
                check(lane1_word_o == w[31:0], "R6", "lane1 word", {32'h0, lane1_word_o}, {32'h0, w[31:0]});
                cnt1 = lb; pend1 = 1;
            end
            if (commit_o) begin
                ncom++;
                check(cyc == last_done + 1, "R9", "commit timing", cyc, last_done + 1);
                check(commit_sysmv_o == sys_acc, "R8", "commit sysmv", {63'h0, commit_sysmv_o}, {63'h0, sys_acc});
                last_com = cyc;
            end
            if (done_o) begin
                got_done = 1'b1;
                check(cyc == last_com + 1, "R9", "done timing", cyc, last_com + 1);
                check(ncom == e_com, "R4", "commit count", ncom, e_com);
                check(k0 == e_iss0, "R4", "lane0 issue count", k0, e_iss0);
                check(k1 == e_iss1, "R6", "lane1 issue count", k1, e_iss1);
                check(nia_valid_o == e_v, (f == 2'd0) ? "R7" : (f == 2'd3 ? "R2" : "R5"),
                      "nia valid", {63'h0, nia_valid_o}, {63'h0, e_v});
                check(nia_o == e_t, (f == 2'd0) ? "R7" : (f == 2'd3 ? "R2" : "R5"),
                      "nia", {32'h0, nia_o}, {32'h0, e_t});
                check(nia_err_o == e_err, "R7", "nia err", {63'h0, nia_err_o}, {63'h0, e_err});
            end
            if (pend0) begin
                if (cnt0 == 0) begin
                    lane0_done_i = 1'b1;
                    lane0_jump_i = (k0 == 1) ? aj : bj;
                    lane0_target_i = (k0 == 1) ? at : bt;
                    lane0_kill_i = (k0 == 1) ? ak : 1'b0;
                    lane0_sysmv_i = (k0 == 1) ? as : bs;
                    if (lane0_sysmv_i) sys_acc = 1'b1;
                    pend0 = 0; last_done = cyc;
                end else cnt0--;
            end
            if (pend1) begin
                if (cnt1 == 0) begin
                    lane1_done_i = 1'b1; lane1_jump_i = bj; lane1_target_i = bt;
                    pend1 = 0; last_done = cyc;
                end else cnt1--;
            end
        end
        if (!got_done) check(1'b0, "R9", "done never seen", 0, 1);
        @(negedge clk);
        lane0_done_i = 1'b0; lane1_done_i = 1'b0;
        check(idle_o == 1'b1 && !done_o && !commit_o, "R11", "idle after done", {63'h0, idle_o}, 64'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(idle_o && !lane0_req_o && !lane1_req_o && !commit_o && !done_o, "R12", "reset state",
              {59'h0, idle_o, lane0_req_o, lane1_req_o, commit_o, done_o}, 64'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_o && !lane0_req_o && !commit_o && !done_o, "R12", "after reset release",
              {63'h0, idle_o}, 64'h1);
        // R2 wide, no jump then jump
        run(mk(2'd3, 32'h1111_2222, 32'h3333_4444), 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 0, 0);
        run(mk(2'd3, 32'h0abc_0001, 32'h0def_0002), 1, 32'h0000_8000, 0, 0, 0, 32'h0, 0, 2, 0, 0);
        // R3 R4 R5 left first, second jumps
        run(mk(2'd1, 32'h0000_00aa, 32'h0000_00bb), 0, 32'h0, 0, 0, 1, 32'h0000_4440, 0, 1, 2, 0);
        // R4 kill in first half suppresses second
        run(mk(2'd1, 32'h0000_0011, 32'h0000_0022), 0, 32'h0, 1, 0, 1, 32'h0000_9990, 0, 0, 0, 0);
        // R8 kill from previous must not carry: second issued
        run(mk(2'd2, 32'h0000_0033, 32'h0000_0044), 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 1, 0);
        // R5 right first, first jumps
        run(mk(2'd2, 32'h0000_0055, 32'h0000_0066), 1, 32'h0000_1230, 0, 0, 0, 32'h0, 0, 3, 0, 0);
        // R7 concurrent merges
        run(mk(2'd0, 32'h0000_0077, 32'h0000_0088), 1, 32'h0000_a000, 0, 0, 0, 32'h0, 0, 0, 2, 0);
        run(mk(2'd0, 32'h0000_0099, 32'h0000_00aa), 0, 32'h0, 0, 0, 1, 32'h0000_b000, 0, 3, 0, 0);
        run(mk(2'd0, 32'h0000_00bb, 32'h0000_00cc), 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, 1, 0);
        run(mk(2'd0, 32'h0000_00dd, 32'h0000_00ee), 1, 32'h0000_c000, 0, 0, 1, 32'h0000_d000, 0, 2, 1, 0);
        // R8 system move visible on both commits, then cleared for next instruction
        run(mk(2'd1, 32'h0000_0101, 32'h0000_0202), 0, 32'h0, 0, 1, 0, 32'h0, 0, 0, 0, 0);
        run(mk(2'd1, 32'h0000_0303, 32'h0000_0404), 0, 32'h0, 0, 0, 0, 32'h0, 1, 1, 1, 0);
        run(mk(2'd0, 32'h0000_0505, 32'h0000_0606), 0, 32'h0, 0, 1, 0, 32'h0, 0, 0, 0, 0);
        // R11 start while busy ignored
        run(mk(2'd2, 32'h0000_0707, 32'h0000_0808), 0, 32'h0, 0, 0, 1, 32'h0000_eee0, 0, 2, 2, 1);
        run(mk(2'd0, 32'h0000_0909, 32'h0000_0a0a), 0, 32'h0, 0, 0, 1, 32'h0000_fff0, 0, 2, 0, 1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule